// File: doc/BRIEF.md
# Quota-Based DMA Channel Arbiter

This block decides which of several DMA channels may use a shared internal transfer interface. Each channel raises a request line and supplies a 3-bit quota code. The code sets how many cache lines the channel may move in one grant. The arbiter grants one requester at a time. It counts the cache-line-done strobes that the granted channel reports. It hands the interface to the next requester once the quota is used up, or as soon as the granted channel withdraws its request. A larger quota gives a channel a bigger share of the bandwidth.

Contention is settled in round-robin order, and the search starts at the channel after the one most recently granted. A channel that is the only requester keeps the grant after it reaches its quota. A two-state machine does the work. In `ARB_IDLE` no channel is granted. In `ARB_OWNED` exactly one channel holds the grant. The machine has these named transitions:

- **CLAIM**: `ARB_IDLE` to `ARB_OWNED`, taken when any request is present.
- **HANDOFF**: `ARB_OWNED` to `ARB_OWNED` with a new owner, taken on a quota expiry while another channel waits, or on a withdrawal while another channel waits.
- **RELEASE**: `ARB_OWNED` to `ARB_IDLE`, taken on a withdrawal when no other channel is requesting.
- **RENEW**: `ARB_OWNED` keeps its owner and clears the count, taken on a quota expiry when no other channel is requesting.

Top module: `dma_quota_arbiter`

## Requirements
- R1: A synchronous active-low reset clears the grant and grant-valid. The first round-robin search after reset begins at channel 0.
- R2: `grant` has at most one bit set, and `grant_valid` equals the OR of `grant`.
- R3: When nothing is granted and at least one request is present, a grant appears one cycle later. It goes to the first requesting channel found at or after the round-robin pointer. The pointer is the channel after the last one granted.
- R4: Quota codes 0, 1, 2, 3 and 4 allow 1, 2, 4, 8 and 16 cache lines per grant. The code for channel i sits in bits [3i+2:3i] of `quota_code`.
- R5: Quota codes 5, 6 and 7 allow 16 cache lines per grant.
- R6: When the line-done strobe that completes the owner's quota arrives while another channel requests, the grant moves in the next cycle. It goes to the next requesting channel in circular order after the owner.
- R7: When the owner is the only requester, it keeps the grant past its quota, and its line count restarts.
- R8: When the owner drops its request, the grant moves in the next cycle to the next requester in circular order. If no channel is requesting, the grant clears.
- R9: Line-done strobes while nothing is granted have no effect. The line count starts from zero at every new grant.
- R10: While the owner keeps requesting and no line-done strobe arrives, the grant does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_CH | Per-channel request lines |
| quota_code | input | NUM_CH*3 | Per-channel 3-bit quota codes, packed |
| line_done | input | 1 | One cache line finished by the granted channel |
| grant | output | NUM_CH | One-hot grant |
| grant_valid | output | 1 | A channel is granted |

## Verification
The hardest case to reach from the ports is a quota expiry that comes just after a lone-owner renewal, with the search then wrapping past the top channel. For this, a single high-numbered channel is left to stream lines past its quota. A lower channel is then raised in the same cycle as a completing strobe, and the grant must move to that lower channel. The test of a count that restarts at a new grant fills the idle time with strobes before the first grant. After the handoff it checks that the new owner keeps the grant for its full quota.

// File: rtl/dqa_pkg.sv
package dqa_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dqa_rr_picker.sv
// Circular search for the first set request at or after a start index.
module dqa_rr_picker #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IDX_W-1:0]  start,
    output logic              found,
    output logic [IDX_W-1:0]  pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        // Walk from the farthest offset down so that the nearest match wins.
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            int c;
            c = (int'(start) + i) % NUM_CH;
            if (req[c]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/dqa_quota_decode.sv
// Turns a quota code into a cache-line limit, a power of two with a ceiling.
module dqa_quota_decode #(
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 4,
    parameter int CNT_W   = MAX_LOG + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit
);
    always_comb begin
        if (int'(code) >= MAX_LOG)
            limit = CNT_W'(1) << MAX_LOG;
        else
            limit = CNT_W'(1) << code;
    end
endmodule

// File: rtl/dma_quota_arbiter.sv
module dma_quota_arbiter
    import dqa_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*CODE_W-1:0] quota_code,
    input  logic                     line_done,
    output logic [NUM_CH-1:0]        grant,
    output logic                     grant_valid
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_W = MAX_LOG + 1;

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [IDX_W-1:0] start_q, start_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic [CNT_W-1:0] limits [NUM_CH];
    logic [CNT_W-1:0] limit_sel;
    logic             found;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] pick_next;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_limit
        dqa_quota_decode #(
            .CODE_W (CODE_W),
            .MAX_LOG(MAX_LOG),
            .CNT_W  (CNT_W)
        ) u_dec (
            .code (quota_code[g*CODE_W +: CODE_W]),
            .limit(limits[g])
        );
    end

    dqa_rr_picker #(
        .NUM_CH(NUM_CH),
        .IDX_W (IDX_W)
    ) u_pick (
        .req  (req),
        .start(start_q),
        .found(found),
        .pick (pick)
    );

    assign limit_sel = limits[owner_q];
    assign pick_next = (int'(pick) == NUM_CH - 1) ? '0 : pick + IDX_W'(1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        start_d = start_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (found) begin                       // CLAIM
                    state_d = ARB_OWNED;
                    owner_d = pick;
                    start_d = pick_next;
                    cnt_d   = '0;
                end
            end
            ARB_OWNED: begin
                if (!req[owner_q]) begin
                    if (found) begin                   // HANDOFF on withdrawal
                        owner_d = pick;
                        start_d = pick_next;
                        cnt_d   = '0;
                    end else begin                     // RELEASE
                        state_d = ARB_IDLE;
                        cnt_d   = '0;
                    end
                end else if (line_done) begin
                    if (cnt_q == limit_sel - CNT_W'(1)) begin
                        cnt_d = '0;                    // RENEW unless handed off
                        if (pick != owner_q) begin     // HANDOFF on quota expiry
                            owner_d = pick;
                            start_d = pick_next;
                        end
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            start_q <= start_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        grant       = '0;
        grant_valid = 1'b0;
        unique case (state_q)
            ARB_IDLE: ;
            ARB_OWNED: begin
                grant[owner_q] = 1'b1;
                grant_valid    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dqa_checker.sv
module dqa_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req,
    input logic              line_done,
    input logic [NUM_CH-1:0] grant,
    input logic              grant_valid
);
    // R2: at most one grant, flag consistent
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (|grant)));

    // R3: idle with a request leads to a grant
    a_r3_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (|req)) |=> grant_valid);

    // R8: withdrawal by the owner moves the grant away
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !(|(grant & req))) |=> (grant != $past(grant)));

    // R10: grant held while owner requests and no line finishes
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && (|(grant & req)) && !line_done) |=> $stable(grant));

    // R7: a lone requester keeps its grant
    a_r7_lone: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && (req == grant)) |=> $stable(grant));
endmodule

bind dma_quota_arbiter dqa_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .line_done  (line_done),
    .grant      (grant),
    .grant_valid(grant_valid)
);

// File: tb/sim_dma_quota_arbiter.sv
module sim_dma_quota_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N*3-1:0] quota_code = '0;
    logic         line_done = 1'b0;
    logic [N-1:0] grant;
    logic         grant_valid;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    dma_quota_arbiter #(.NUM_CH(N)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .quota_code (quota_code),
        .line_done  (line_done),
        .grant      (grant),
        .grant_valid(grant_valid)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [N-1:0] exp);
        checks++;
        if (grant !== exp || grant_valid !== (|exp)) begin
            errors++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant, grant_valid, exp, |exp);
        end
    endtask

    task automatic set_code(int ch, logic [2:0] c);
        quota_code[ch*3 +: 3] = c;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; line_done = 1'b0; quota_code = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req = 4'b1111;
        step(); step();
        check("R1 reset clears grant", 4'b0000);
        req = 4'b1010;
        rst_n = 1'b1;
        step();
        check("R1 R3 first search from ch0", 4'b0010);
    endtask

    task automatic t_quota();
        for (int code = 0; code < 8; code++) begin
            int lines;
            lines = (code >= 4) ? 16 : (1 << code);
            do_reset();
            set_code(0, 3'(code));
            req = 4'b0011;
            step();
            check("R3 claim ch0", 4'b0001);
            line_done = 1'b1;
            for (int k = 1; k < lines; k++) begin
                step();
                if (k == lines - 1)
                    check(code >= 4 ? "R5 quota hold" : "R4 quota hold", 4'b0001);
            end
            step();
            check(code >= 4 ? "R5 quota expiry" : "R4 quota expiry", 4'b0010);
            line_done = 1'b0;
        end
    endtask

    task automatic t_lone();
        do_reset();
        req = 4'b0100;
        step();
        check("R3 claim lone ch2", 4'b0100);
        line_done = 1'b1;
        for (int k = 0; k < 5; k++) step();
        check("R7 lone keeps grant", 4'b0100);
        req = 4'b0110;
        step();
        check("R6 expiry wraps to ch1", 4'b0010);
        line_done = 1'b0;
    endtask

    task automatic t_rr();
        do_reset();
        req = 4'b1111;
        step();
        check("R6 rr start ch0", 4'b0001);
        line_done = 1'b1;
        step(); check("R6 rr ch1", 4'b0010);
        step(); check("R6 rr ch2", 4'b0100);
        step(); check("R6 rr ch3", 4'b1000);
        step(); check("R6 rr wrap ch0", 4'b0001);
        line_done = 1'b0;
        step(); step();
        check("R10 hold without strobe", 4'b0001);
    endtask

    task automatic t_drop();
        do_reset();
        set_code(0, 3'd3);
        req = 4'b0101;
        step();
        check("R3 claim ch0", 4'b0001);
        req = 4'b0100;
        step();
        check("R8 drop hands to ch2", 4'b0100);
        req = 4'b0000;
        step();
        check("R8 drop with none clears", 4'b0000);
        req = 4'b0011;
        step();
        check("R3 pointer after ch2 picks ch0", 4'b0001);
    endtask

    task automatic t_idle_done();
        do_reset();
        set_code(0, 3'd1);
        set_code(1, 3'd1);
        line_done = 1'b1;
        step(); step(); step();
        check("R9 strobe while idle", 4'b0000);
        line_done = 1'b0;
        req = 4'b0011;
        step();
        check("R9 claim ch0", 4'b0001);
        line_done = 1'b1;
        step();
        check("R9 idle strobes not counted", 4'b0001);
        step();
        check("R6 expiry to ch1", 4'b0010);
        step();
        check("R9 count restarts on new grant", 4'b0010);
        step();
        check("R6 expiry back to ch0", 4'b0001);
        line_done = 1'b0;
    endtask

    initial begin
        t_reset();
        t_quota();
        t_lone();
        t_rr();
        t_drop();
        t_idle_done();
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule